// File: doc/BRIEF.md
# Colour Lookup Table Host Register Front End

This block sits between a host register bus and a 256-entry colour lookup table that feeds a display pipeline. The host sees four word-wide registers, picked by a two-bit select: a pointer, a colour-map data port, an indexed control port and a cursor byte. Only the most significant byte of each 32-bit word carries data. The pointer selects a palette entry for colour loading and also selects one of four control registers reached through the control port.

A palette entry is loaded by three colour-map writes in a fixed order: red, then green, then blue. Red and green are held in staging registers and the entry is written as a whole on the blue write, after which the pointer steps to the next entry. The display side presents a pixel index every cycle and receives 24-bit RGB one cycle later, after the index has been ANDed with a read-mask control register.

Top module: `clut_regfront`

## Requirements
- R1: After reset the pointer is 0, the colour sub-sequence waits for red, every palette entry is 0x000000, the cursor byte is 0 and the display output is 0.
- R2: Only bits 31:24 of a written word are used; bits 23:0 have no effect, and every read returns its byte in bits 31:24 with bits 23:0 zero.
- R3: A write to the pointer register (select 0) loads the pointer from bits 31:24 and restarts the colour sub-sequence at red, discarding any staged red or green.
- R4: Colour-map writes (select 1) take red, green and blue in that order for the entry named by the pointer.
- R5: On the blue write the pointer increments by one, wrapping from 255 to 0, and the sub-sequence returns to red.
- R6: A palette entry changes only on the blue write and then takes all three components together; after only red and green the display still returns the old colour.
- R7: Control writes (select 2) reach control register 4 to 7 when the pointer holds that value; with any other pointer value a control write changes nothing and a control read returns 0.
- R8: After reset control register 4 (read mask) is 0xFF, control register 6 (overlay control) is 0x73, and registers 5 and 7 are 0x00.
- R9: The display output in a cycle equals the palette entry at (pixel index AND read mask) as sampled at the previous clock edge, packed red in bits 23:16, green 15:8, blue 7:0.
- R10: A colour-map read (select 1) returns the committed component of the entry at the pointer that the next colour-map write would replace (red, green or blue by sub-sequence position) and changes no state; a pointer read (select 0) returns the pointer.
- R11: A write to the cursor register (select 3) stores bits 31:24, read back through select 3, and leaves the pointer and sub-sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Write register select: 0 pointer, 1 colour map, 2 control, 3 cursor |
| wr_data | input | 32 | Write word; data in bits 31:24 |
| rd_sel | input | 2 | Read register select, same encoding as wr_sel |
| rd_data | output | 32 | Combinational read word for rd_sel |
| pix_idx | input | 8 | Display pixel index |
| pix_rgb | output | 24 | Looked-up colour, one cycle after pix_idx |

## Verification
The assertions assume the write select is only acted on while wr_en is high and that reset is held across at least one clock edge before any write, so that the first sampled past values are the reset values. They also assume that one write at most is presented per cycle, which the single strobe guarantees. The stimulus drives all inputs half a cycle away from the sampling edge, holds wr_en low throughout reset, and mixes directed sequences (interrupted colour loads, pointer wrap, control writes at out-of-range pointers, a narrowed read mask) with a long run of random writes and lookups checked against a behavioural model every cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANE_LSB = WORD_W - LANE_W;
  localparam int RGB_W = 3 * LANE_W;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_CMAP = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CURS = 2'd3
  } regsel_t;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  // Extract the data lane from a full bus word.
  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] word);
    return word[WORD_W-1:LANE_LSB];
  endfunction

  // Place a byte into the data lane of a bus word.
  function automatic logic [WORD_W-1:0] place_lane(input logic [LANE_W-1:0] b);
    return {b, {LANE_LSB{1'b0}}};
  endfunction

  // Advance the colour sub-sequence by one component.
  function automatic phase_t phase_after(input phase_t p);
    case (p)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction

  // Pick the component of a packed entry that matches a phase.
  function automatic logic [LANE_W-1:0] pick_component(input logic [RGB_W-1:0] rgb,
                                                       input phase_t p);
    case (p)
      PH_RED:  return rgb[RGB_W-1 -: LANE_W];
      PH_GRN:  return rgb[2*LANE_W-1 -: LANE_W];
      default: return rgb[LANE_W-1:0];
    endcase
  endfunction

endpackage

// File: rtl/clut_ptr_seq.sv
module clut_ptr_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ptr_wr,
  input  logic                cmap_wr,
  input  logic [LANE_W-1:0]   lane,
  output logic [IDX_W-1:0]    idx,
  output phase_t              phase,
  output logic                commit_evt,
  output logic [RGB_W-1:0]    commit_rgb
);

  logic [LANE_W-1:0] stage_r;
  logic [LANE_W-1:0] stage_g;

  // Blue write completes an entry; red and green only stage.
  assign commit_evt = cmap_wr && !ptr_wr && (phase == PH_BLU);
  assign commit_rgb = {stage_r, stage_g, lane};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      phase   <= PH_RED;
      stage_r <= '0;
      stage_g <= '0;
    end else if (ptr_wr) begin
      idx   <= lane[IDX_W-1:0];
      phase <= PH_RED;
    end else if (cmap_wr) begin
      phase <= phase_after(phase);
      case (phase)
        PH_RED:  stage_r <= lane;
        PH_GRN:  stage_g <= lane;
        default: idx     <= idx + IDX_W'(1);
      endcase
    end
  end

endmodule

// File: rtl/clut_ctrl_bank.sv
module clut_ctrl_bank
  import clut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int BASE  = 4,
  parameter int COUNT = 4,
  parameter logic [COUNT*LANE_W-1:0] INIT = {8'h00, 8'h73, 8'h00, 8'hFF}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ctrl_wr,
  input  logic [IDX_W-1:0]          idx,
  input  logic [LANE_W-1:0]         lane,
  output logic                      hit,
  output logic [LANE_W-1:0]         rd_val,
  output logic [LANE_W-1:0]         mask,
  output logic [COUNT*LANE_W-1:0]   flat
);

  localparam int SLOT_W = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [IDX_W:0] LO = (IDX_W+1)'(BASE);
  localparam logic [IDX_W:0] HI = (IDX_W+1)'(BASE + COUNT);

  logic [IDX_W:0]  idx_ext;
  logic [IDX_W:0]  offset;
  logic [SLOT_W-1:0] slot;
  logic [LANE_W-1:0] regs [COUNT];

  assign idx_ext = {1'b0, idx};
  assign hit     = (idx_ext >= LO) && (idx_ext < HI);
  assign offset  = idx_ext - LO;
  assign slot    = offset[SLOT_W-1:0];

  for (genvar k = 0; k < COUNT; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k] <= INIT[k*LANE_W +: LANE_W];
      else if (ctrl_wr && hit && (slot == SLOT_W'(k)))
        regs[k] <= lane;
    end
    assign flat[k*LANE_W +: LANE_W] = regs[k];
  end

  assign rd_val = hit ? regs[slot] : '0;
  assign mask   = regs[0];

endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [RGB_W-1:0]   wr_rgb,
  input  logic [IDX_W-1:0]   host_idx,
  output logic [RGB_W-1:0]   host_rgb,
  input  logic [IDX_W-1:0]   look_idx,
  input  logic [IDX_W-1:0]   look_mask,
  output logic [RGB_W-1:0]   look_rgb
);

  localparam int DEPTH = 1 << IDX_W;

  logic [RGB_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0] eff_idx;

  function automatic logic [IDX_W-1:0] apply_mask(input logic [IDX_W-1:0] i,
                                                  input logic [IDX_W-1:0] m);
    return i & m;
  endfunction

  assign eff_idx  = apply_mask(look_idx, look_mask);
  assign host_rgb = mem[host_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_rgb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) look_rgb <= '0;
    else        look_rgb <= mem[eff_idx];
  end

endmodule

// File: rtl/clut_regfront.sv
module clut_regfront
  import clut_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int CTRL_BASE  = 4,
  parameter int CTRL_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic [1:0]        rd_sel,
  output logic [31:0]       rd_data,
  input  logic [7:0]        pix_idx,
  output logic [23:0]       pix_rgb
);

  localparam int CTRL_FLAT_W = CTRL_COUNT * LANE_W;

  // Decoded write events, named for the checker.
  logic ptr_wr_evt;
  logic cmap_wr_evt;
  logic ctrl_wr_evt;
  logic curs_wr_evt;
  logic commit_evt;

  logic [LANE_W-1:0]      lane;
  logic [IDX_W-1:0]       cur_idx;
  phase_t                 cur_phase;
  logic [1:0]             phase_bits;
  logic [RGB_W-1:0]       commit_rgb;
  logic [RGB_W-1:0]       host_rgb;
  logic                   ctrl_hit;
  logic [LANE_W-1:0]      ctrl_rd;
  logic [LANE_W-1:0]      read_mask;
  logic [CTRL_FLAT_W-1:0] ctrl_flat;
  logic [LANE_W-1:0]      cursor_q;
  logic [23:0]            unused_low;

  assign lane        = lane_of(wr_data);
  assign unused_low  = wr_data[23:0];
  assign ptr_wr_evt  = wr_en && (regsel_t'(wr_sel) == SEL_PTR);
  assign cmap_wr_evt = wr_en && (regsel_t'(wr_sel) == SEL_CMAP);
  assign ctrl_wr_evt = wr_en && (regsel_t'(wr_sel) == SEL_CTRL);
  assign curs_wr_evt = wr_en && (regsel_t'(wr_sel) == SEL_CURS);
  assign phase_bits  = cur_phase;

  clut_ptr_seq #(.IDX_W(IDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ptr_wr_evt),
    .cmap_wr    (cmap_wr_evt),
    .lane       (lane),
    .idx        (cur_idx),
    .phase      (cur_phase),
    .commit_evt (commit_evt),
    .commit_rgb (commit_rgb)
  );

  clut_ctrl_bank #(
    .IDX_W (IDX_W),
    .BASE  (CTRL_BASE),
    .COUNT (CTRL_COUNT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr_evt),
    .idx     (cur_idx),
    .lane    (lane),
    .hit     (ctrl_hit),
    .rd_val  (ctrl_rd),
    .mask    (read_mask),
    .flat    (ctrl_flat)
  );

  clut_table #(.IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (commit_evt),
    .wr_idx    (cur_idx),
    .wr_rgb    (commit_rgb),
    .host_idx  (cur_idx),
    .host_rgb  (host_rgb),
    .look_idx  (pix_idx[IDX_W-1:0]),
    .look_mask (read_mask[IDX_W-1:0]),
    .look_rgb  (pix_rgb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cursor_q <= '0;
    else if (curs_wr_evt) cursor_q <= lane;
  end

  always_comb begin
    case (regsel_t'(rd_sel))
      SEL_PTR:  rd_data = place_lane(LANE_W'(cur_idx));
      SEL_CMAP: rd_data = place_lane(pick_component(host_rgb, cur_phase));
      SEL_CTRL: rd_data = place_lane(ctrl_rd);
      default:  rd_data = place_lane(cursor_q);
    endcase
  end

endmodule

// File: rtl/clut_regfront_chk.sv
module clut_regfront_chk #(
  parameter int IDX_W      = 8,
  parameter int CTRL_BASE  = 4,
  parameter int CTRL_COUNT = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [1:0]               wr_sel,
  input logic [31:0]              wr_data,
  input logic [IDX_W-1:0]         cur_idx,
  input logic [1:0]               phase_bits,
  input logic                     commit_evt,
  input logic [CTRL_COUNT*8-1:0]  ctrl_flat
);

  logic ctrl_in_range;
  assign ctrl_in_range = (int'(cur_idx) >= CTRL_BASE) &&
                         (int'(cur_idx) < CTRL_BASE + CTRL_COUNT);

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (cur_idx == $past(wr_data[31:24]) && phase_bits == 2'd0));

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && phase_bits != 2'd2)
      |=> (phase_bits == $past(phase_bits) + 2'd1 && $stable(cur_idx)));

  assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_bits != 2'd3);

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && phase_bits == 2'd2)
      |=> (cur_idx == $past(cur_idx) + IDX_W'(1) && phase_bits == 2'd0));

  assert_commit_only_blue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (wr_en && wr_sel == 2'd1 && phase_bits == 2'd2));

  assert_ctrl_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !ctrl_in_range) |=> $stable(ctrl_flat));

  assert_cursor_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(cur_idx) && $stable(phase_bits)));

endmodule

bind clut_regfront clut_regfront_chk #(
  .IDX_W      (IDX_W),
  .CTRL_BASE  (CTRL_BASE),
  .CTRL_COUNT (CTRL_COUNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cur_idx    (cur_idx),
  .phase_bits (phase_bits),
  .commit_evt (commit_evt),
  .ctrl_flat  (ctrl_flat)
);

// File: tb/clut_regfront_tb.sv
`timescale 1ns/1ps
module clut_regfront_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit live = 0;

  always #4 clk = ~clk;

  clut_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  // Behavioural reference model
  int m_r[256], m_g[256], m_b[256];
  int m_ptr, m_ph, m_sr, m_sg, m_curs;
  int m_ctl[4];
  int m_pix;

  task automatic model_reset();
    for (int k = 0; k < 256; k++) begin m_r[k] = 0; m_g[k] = 0; m_b[k] = 0; end
    m_ptr = 0; m_ph = 0; m_sr = 0; m_sg = 0; m_curs = 0; m_pix = 0;
    m_ctl[0] = 'hFF; m_ctl[1] = 0; m_ctl[2] = 'h73; m_ctl[3] = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int e, v;
      e = pix_idx & m_ctl[0];
      m_pix = (m_r[e] << 16) | (m_g[e] << 8) | m_b[e];
      v = wr_data >> 24;
      if (wr_en) begin
        case (wr_sel)
          2'd0: begin m_ptr = v; m_ph = 0; end
          2'd1: begin
            if (m_ph == 0) begin m_sr = v; m_ph = 1; end
            else if (m_ph == 1) begin m_sg = v; m_ph = 2; end
            else begin
              m_r[m_ptr] = m_sr; m_g[m_ptr] = m_sg; m_b[m_ptr] = v;
              m_ptr = (m_ptr + 1) % 256; m_ph = 0;
            end
          end
          2'd2: if (m_ptr >= 4 && m_ptr <= 7) m_ctl[m_ptr-4] = v;
          default: m_curs = v;
        endcase
      end
    end
  end

  function automatic logic [31:0] model_rd(input int s);
    int c;
    case (s)
      0: c = m_ptr;
      1: c = (m_ph == 0) ? m_r[m_ptr] : (m_ph == 1) ? m_g[m_ptr] : m_b[m_ptr];
      2: c = (m_ptr >= 4 && m_ptr <= 7) ? m_ctl[m_ptr-4] : 0;
      default: c = m_curs;
    endcase
    return 32'(c) << 24;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (live) begin
      #3;
      check("R10", "read port vs model", rd_data, model_rd(int'(rd_sel)));
      check("R9", "display port vs model", {8'h00, pix_rgb}, 32'(m_pix));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] v);
    @(negedge clk); pix_idx = i;
    @(negedge clk); #1; v = pix_rgb;
  endtask

  initial begin
    logic [31:0] v;
    logic [23:0] c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; live = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1", "pointer after reset", v, 32'h0);
    rd(2'd3, v); check("R1", "cursor after reset", v, 32'h0);
    look(8'h42, c); check("R1", "entry after reset", {8'h0, c}, 32'h0);

    // R8 control reset values
    wr(2'd0, 32'h04000000); rd(2'd2, v); check("R8", "read mask reset", v, 32'hFF000000);
    wr(2'd0, 32'h06000000); rd(2'd2, v); check("R8", "overlay reset", v, 32'h73000000);
    wr(2'd0, 32'h05000000); rd(2'd2, v); check("R8", "ctrl5 reset", v, 32'h0);

    // R2 low bits ignored
    wr(2'd0, 32'h12ABCDEF); rd(2'd0, v); check("R2", "pointer low bits", v, 32'h12000000);

    // R4 three writes load one entry
    wr(2'd0, 32'h10000000);
    wr(2'd1, 32'h11FFFFFF); wr(2'd1, 32'h22000001); wr(2'd1, 32'h33123456);
    look(8'h10, c); check("R4", "loaded entry", {8'h0, c}, 32'h112233);
    rd(2'd0, v); check("R5", "pointer after blue", v, 32'h11000000);

    // R10 colour read follows phase without advancing
    wr(2'd0, 32'h10000000);
    rd(2'd1, v); check("R10", "red readback", v, 32'h11000000);
    wr(2'd1, 32'h77000000);
    rd(2'd1, v); check("R10", "green readback after staged red", v, 32'h22000000);
    rd(2'd1, v); check("R10", "read has no side effect", v, 32'h22000000);

    // R6 atomic commit
    wr(2'd0, 32'h20000000);
    wr(2'd1, 32'hAA000000); wr(2'd1, 32'hBB000000);
    look(8'h20, c); check("R6", "entry unchanged before blue", {8'h0, c}, 32'h0);
    wr(2'd1, 32'hCC000000);
    look(8'h20, c); check("R6", "entry after blue", {8'h0, c}, 32'hAABBCC);

    // R3 pointer write restarts the sub-sequence
    wr(2'd0, 32'h30000000); wr(2'd1, 32'hEE000000);
    wr(2'd0, 32'h30000000);
    wr(2'd1, 32'h01000000); wr(2'd1, 32'h02000000); wr(2'd1, 32'h03000000);
    look(8'h30, c); check("R3", "restart discards staged red", {8'h0, c}, 32'h010203);

    // R5 wrap from 255
    wr(2'd0, 32'hFF000000);
    wr(2'd1, 32'h40000000); wr(2'd1, 32'h50000000); wr(2'd1, 32'h60000000);
    rd(2'd0, v); check("R5", "pointer wraps to 0", v, 32'h0);
    look(8'hFF, c); check("R5", "entry 255", {8'h0, c}, 32'h405060);

    // R7 control write in and out of range
    wr(2'd0, 32'h05000000); wr(2'd2, 32'h5A000000);
    rd(2'd2, v); check("R7", "ctrl5 written", v, 32'h5A000000);
    wr(2'd0, 32'h02000000); wr(2'd2, 32'h99000000);
    rd(2'd2, v); check("R7", "out-of-range ctrl read", v, 32'h0);
    rd(2'd0, v); check("R7", "pointer kept", v, 32'h02000000);
    wr(2'd0, 32'h04000000); rd(2'd2, v); check("R7", "mask untouched", v, 32'hFF000000);
    wr(2'd0, 32'h07000000); rd(2'd2, v); check("R7", "ctrl7 untouched", v, 32'h0);

    // R9 read mask applied before lookup
    wr(2'd0, 32'h0F000000);
    wr(2'd1, 32'h0A000000); wr(2'd1, 32'h0B000000); wr(2'd1, 32'h0C000000);
    wr(2'd0, 32'h04000000); wr(2'd2, 32'h0F000000);
    look(8'hFF, c); check("R9", "masked lookup 0xFF", {8'h0, c}, 32'h0A0B0C);
    wr(2'd2, 32'hFF000000);
    look(8'hFF, c); check("R9", "mask restored", {8'h0, c}, 32'h405060);

    // R11 cursor write
    wr(2'd0, 32'h21000000); wr(2'd1, 32'h01000000);
    wr(2'd3, 32'hC3ABCDEF);
    rd(2'd3, v); check("R11", "cursor value", v, 32'hC3000000);
    rd(2'd0, v); check("R11", "pointer unchanged", v, 32'h21000000);
    rd(2'd1, v); check("R11", "phase unchanged", v, 32'h00000000);

    // Random traffic compared every cycle
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      wr_en   = ($urandom_range(0, 3) != 0);
      wr_sel  = 2'($urandom_range(0, 3));
      wr_data = $urandom;
      if (wr_sel == 2'd0 && $urandom_range(0, 1) == 1)
        wr_data[31:24] = 8'($urandom_range(3, 8));
      rd_sel  = 2'($urandom_range(0, 3));
      pix_idx = 8'($urandom);
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    live = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule